// File: doc/BRIEF.md
# Luma Gain and Sync Inserter

This block prepares the luminance half of a composite video signal. Ten-bit luma samples enter on a pixel strobe, together with flags marking horizontal sync, vertical sync and active video. Each sample first passes a fixed delay so that it meets the chroma path in step. A programmable fixed-point gain then scales it. After the gain, the block replaces the sample with a sync level, a blanking level or a pedestal-lifted picture level, depending on the flags.

Whenever the kind of signal changes (entering or leaving sync, or starting or ending active video), the output moves to the new level on a linear ramp and never jumps in one step. The shaped stream then passes a seven-tap half-band interpolator, which emits two samples for every pixel. A DAC can then run at twice the pixel rate with a simpler analog filter.

All level and gain settings are quasi-static inputs. They are changed only while no pixel is in flight. The pixel strobe must be separated by at least one idle clock, because each pixel occupies two output cycles.

Top module: `luma_sync_inserter`

## Requirements
- R1: Each pixel takes effect exactly DLY pixel strobes after it enters (default 6). The DLY strobes that follow reset therefore process a zero sample with all flags low, which appears as the blank level.
- R2: The gain is unsigned with 1 integer bit and 9 fraction bits (0x200 is unity). The scaled value is floor(luma*gain/512), and it saturates to 1023 when it exceeds 10 bits.
- R3: When hsync_in or vsync_in is high, the settled level is sync_lvl, whatever the value of active_in.
- R4: During active video with no sync, the settled level is black_lvl plus the scaled luma, saturated to 1023.
- R5: When sync and active video are both low, the settled level is blank_lvl.
- R6: When the region changes (region codes: blank, active, sync), the shaped value on the k-th pixel after the change is S + floor((T-S)*k/4) for k = 1..4. Here S is the last shaped value before the change and T is the current level. From k = 4 on, the value equals T.
- R7: A region change in the middle of a ramp restarts the ramp, with S taken as the shaped value of the previous pixel.
- R8: Every input pixel yields exactly two output samples on out_valid, in two consecutive clock cycles.
- R9: For shaped history s0 (newest) to s3, the first output of a pixel is s2. The second output is (9*(s2+s1) - s3 - s0 + 8) >> 4 (arithmetic shift), clipped to 0..1023. The history is zero after reset.
- R10: During and right after reset, out_valid is low and out_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock running at twice the pixel rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid | input | 1 | One-cycle strobe marking a new pixel; needs at least one idle cycle between strobes |
| luma_in | input | 10 | Luma sample |
| hsync_in | input | 1 | Horizontal sync flag for this pixel |
| vsync_in | input | 1 | Vertical sync flag for this pixel |
| active_in | input | 1 | Active picture flag for this pixel |
| gain | input | 10 | Luma gain, 1.9 unsigned fixed point |
| black_lvl | input | 10 | Pedestal added during active video |
| blank_lvl | input | 10 | Level during blanking |
| sync_lvl | input | 10 | Level during sync |
| out_valid | output | 1 | Double-rate output strobe |
| out_data | output | 10 | Interpolated luma output |

## Verification
A wrong delay depth shifts the whole output stream by whole pixels, so the first picture sample appears two outputs too early or too late. A corrupted ramp count or ramp start shows up on the first one to four pixels after any flag change, as an intermediate value off the straight line. After that the output settles and the fault is hidden again. A fault in the interpolator history touches every second output sample within one or two pixels. A bad gain or saturation path shows on every active pixel at bright luma codes.

// File: rtl/luma_pkg.sv
package luma_pkg;

   typedef enum logic [1:0] {
      REG_BLANK  = 2'd0,
      REG_ACTIVE = 2'd1,
      REG_SYNC   = 2'd2
   } lregion_e;

endpackage

// File: rtl/luma_delay_line.sv
module luma_delay_line #(
   parameter int DW  = 10,
   parameter int DLY = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [DW-1:0] in_luma,
   input  logic          in_hs,
   input  logic          in_vs,
   input  logic          in_act,
   output logic          out_vld,
   output logic [DW-1:0] out_luma,
   output logic          out_hs,
   output logic          out_vs,
   output logic          out_act
);

   localparam int EW = DW + 3;

   logic [EW-1:0] entry_in;
   logic [EW-1:0] entry_out;

   assign entry_in = {in_hs, in_vs, in_act, in_luma};

   generate
      if (DLY == 0) begin : g_nodelay
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               entry_out <= '0;
            end else if (in_vld) begin
               entry_out <= entry_in;
            end
         end
      end else begin : g_shift
         logic [EW-1:0] stage [DLY];
         for (genvar i = 0; i < DLY; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stage[i] <= '0;
               end else if (in_vld) begin
                  if (i == 0) begin
                     stage[i] <= entry_in;
                  end else begin
                     stage[i] <= stage[(i == 0) ? 0 : i-1];
                  end
               end
            end
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               entry_out <= '0;
            end else if (in_vld) begin
               entry_out <= stage[DLY-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
      end else begin
         out_vld <= in_vld;
      end
   end

   assign out_luma = entry_out[DW-1:0];
   assign out_act  = entry_out[DW];
   assign out_vs   = entry_out[DW+1];
   assign out_hs   = entry_out[DW+2];

endmodule

// File: rtl/luma_level_gen.sv
module luma_level_gen
   import luma_pkg::*;
#(
   parameter int DW = 10,
   parameter int GW = 10,
   parameter int GF = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [DW-1:0] in_luma,
   input  logic          in_hs,
   input  logic          in_vs,
   input  logic          in_act,
   input  logic [GW-1:0] gain,
   input  logic [DW-1:0] black_lvl,
   input  logic [DW-1:0] blank_lvl,
   input  logic [DW-1:0] sync_lvl,
   output logic          out_vld,
   output logic [DW-1:0] out_level,
   output lregion_e      out_region
);

   localparam int PW = DW + GW;
   localparam int SW = PW - GF;
   localparam logic [DW-1:0] MAXV = {DW{1'b1}};

   logic [PW-1:0] product;
   logic [SW-1:0] shifted;
   logic [DW-1:0] scaled;
   logic [DW:0]   lifted;
   logic [DW-1:0] picture;
   logic [DW-1:0] level_n;
   lregion_e      region_n;

   assign product = PW'(in_luma) * PW'(gain);
   assign shifted = product[PW-1:GF];

   generate
      if (SW > DW) begin : g_sat
         logic ovf;
         assign ovf    = |shifted[SW-1:DW];
         assign scaled = ovf ? MAXV : shifted[DW-1:0];
      end else begin : g_nosat
         assign scaled = DW'(shifted);
      end
   endgenerate

   assign lifted  = {1'b0, black_lvl} + {1'b0, scaled};
   assign picture = lifted[DW] ? MAXV : lifted[DW-1:0];

   always_comb begin
      if (in_hs || in_vs) begin
         region_n = REG_SYNC;
         level_n  = sync_lvl;
      end else if (in_act) begin
         region_n = REG_ACTIVE;
         level_n  = picture;
      end else begin
         region_n = REG_BLANK;
         level_n  = blank_lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld    <= 1'b0;
         out_level  <= '0;
         out_region <= REG_BLANK;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_level  <= level_n;
            out_region <= region_n;
         end
      end
   end

endmodule

// File: rtl/luma_edge_ramp.sv
module luma_edge_ramp
   import luma_pkg::*;
#(
   parameter int DW       = 10,
   parameter int RAMP_LEN = 4,
   parameter int CW       = $clog2(RAMP_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [DW-1:0] in_level,
   input  lregion_e      in_region,
   output logic          out_vld,
   output logic [DW-1:0] out_val,
   output logic [CW-1:0] out_cnt,
   output lregion_e      region_q
);

   localparam int RLOG = $clog2(RAMP_LEN);
   localparam int PW   = DW + CW + 3;
   localparam logic [CW-1:0] FULL = CW'(RAMP_LEN);

   logic [DW-1:0] start_q;
   logic [DW-1:0] start_n;
   logic [CW-1:0] cnt_n;
   logic [DW-1:0] shaped;
   logic          changed;

   assign changed = (in_region != region_q);

   always_comb begin
      if (changed) begin
         cnt_n   = CW'(1);
         start_n = out_val;
      end else if (out_cnt < FULL) begin
         cnt_n   = out_cnt + CW'(1);
         start_n = start_q;
      end else begin
         cnt_n   = out_cnt;
         start_n = start_q;
      end
   end

   generate
      if (RAMP_LEN == 1) begin : g_step
         assign shaped = in_level;
      end else begin : g_ramp
         logic signed [PW-1:0] diff;
         logic signed [PW-1:0] prod;
         logic signed [PW-1:0] step;
         logic signed [PW-1:0] sum;
         assign diff   = $signed({{(PW-DW){1'b0}}, in_level}) - $signed({{(PW-DW){1'b0}}, start_n});
         assign prod   = diff * $signed({{(PW-CW){1'b0}}, cnt_n});
         assign step   = prod >>> RLOG;
         assign sum    = $signed({{(PW-DW){1'b0}}, start_n}) + step;
         assign shaped = sum[DW-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_val  <= '0;
         out_cnt  <= FULL;
         start_q  <= '0;
         region_q <= REG_BLANK;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_val  <= shaped;
            out_cnt  <= cnt_n;
            start_q  <= start_n;
            region_q <= in_region;
         end
      end
   end

endmodule

// File: rtl/luma_halfband_x2.sv
module luma_halfband_x2 #(
   parameter int DW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [DW-1:0] in_val,
   output logic          out_vld,
   output logic [DW-1:0] out_val
);

   localparam int NH = 4;
   localparam int AW = DW + 7;
   localparam logic [DW-1:0] MAXV = {DW{1'b1}};

   logic [DW-1:0] hist [NH];
   logic          odd_pending;
   logic signed [AW-1:0] acc;
   logic [DW-1:0] odd_val;

   for (genvar i = 0; i < NH; i++) begin : g_hist
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist[i] <= '0;
         end else if (in_vld) begin
            if (i == 0) begin
               hist[i] <= in_val;
            end else begin
               hist[i] <= hist[(i == 0) ? 0 : i-1];
            end
         end
      end
   end

   assign acc = AW'(9) * ($signed({{(AW-DW){1'b0}}, hist[2]}) + $signed({{(AW-DW){1'b0}}, hist[1]}))
              - $signed({{(AW-DW){1'b0}}, hist[3]})
              - $signed({{(AW-DW){1'b0}}, hist[0]})
              + AW'(8);

   always_comb begin
      logic signed [AW-1:0] q;
      q = acc >>> 4;
      if (q < 0) begin
         odd_val = '0;
      end else if (q > $signed({{(AW-DW){1'b0}}, MAXV})) begin
         odd_val = MAXV;
      end else begin
         odd_val = q[DW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld     <= 1'b0;
         out_val     <= '0;
         odd_pending <= 1'b0;
      end else if (in_vld) begin
         out_vld     <= 1'b1;
         out_val     <= hist[1];
         odd_pending <= 1'b1;
      end else if (odd_pending) begin
         out_vld     <= 1'b1;
         out_val     <= odd_val;
         odd_pending <= 1'b0;
      end else begin
         out_vld <= 1'b0;
      end
   end

endmodule

// File: rtl/luma_sync_inserter.sv
module luma_sync_inserter
   import luma_pkg::*;
#(
   parameter int DW       = 10,
   parameter int GW       = 10,
   parameter int GF       = 9,
   parameter int DLY      = 6,
   parameter int RAMP_LEN = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_valid,
   input  logic [DW-1:0] luma_in,
   input  logic          hsync_in,
   input  logic          vsync_in,
   input  logic          active_in,
   input  logic [GW-1:0] gain,
   input  logic [DW-1:0] black_lvl,
   input  logic [DW-1:0] blank_lvl,
   input  logic [DW-1:0] sync_lvl,
   output logic          out_valid,
   output logic [DW-1:0] out_data
);

   localparam int CW = $clog2(RAMP_LEN + 1);

   initial begin
      assert (DW >= 4) else $fatal(1, "DW too small");
      assert (GF < GW) else $fatal(1, "gain needs an integer bit");
      assert (DLY >= 0) else $fatal(1, "DLY negative");
      assert (RAMP_LEN >= 1 && (RAMP_LEN & (RAMP_LEN - 1)) == 0)
         else $fatal(1, "RAMP_LEN must be a power of two");
   end

   logic          d_vld;
   logic [DW-1:0] d_luma;
   logic          d_hs, d_vs, d_act;
   logic          lv_vld;
   logic [DW-1:0] lv_level;
   lregion_e      lv_region;
   logic          rp_vld;
   logic [DW-1:0] rp_val;
   logic [CW-1:0] rp_cnt;
   lregion_e      rp_region;

   luma_delay_line #(.DW(DW), .DLY(DLY)) i_delay (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (pix_valid),
      .in_luma (luma_in),
      .in_hs   (hsync_in),
      .in_vs   (vsync_in),
      .in_act  (active_in),
      .out_vld (d_vld),
      .out_luma(d_luma),
      .out_hs  (d_hs),
      .out_vs  (d_vs),
      .out_act (d_act)
   );

   luma_level_gen #(.DW(DW), .GW(GW), .GF(GF)) i_level (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (d_vld),
      .in_luma   (d_luma),
      .in_hs     (d_hs),
      .in_vs     (d_vs),
      .in_act    (d_act),
      .gain      (gain),
      .black_lvl (black_lvl),
      .blank_lvl (blank_lvl),
      .sync_lvl  (sync_lvl),
      .out_vld   (lv_vld),
      .out_level (lv_level),
      .out_region(lv_region)
   );

   luma_edge_ramp #(.DW(DW), .RAMP_LEN(RAMP_LEN), .CW(CW)) i_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (lv_vld),
      .in_level (lv_level),
      .in_region(lv_region),
      .out_vld  (rp_vld),
      .out_val  (rp_val),
      .out_cnt  (rp_cnt),
      .region_q (rp_region)
   );

   luma_halfband_x2 #(.DW(DW)) i_interp (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_vld (rp_vld),
      .in_val (rp_val),
      .out_vld(out_valid),
      .out_val(out_data)
   );

endmodule

// File: rtl/luma_sync_inserter_chk.sv
module luma_sync_inserter_chk
   import luma_pkg::*;
#(
   parameter int DW       = 10,
   parameter int RAMP_LEN = 4,
   parameter int CW       = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          lv_vld,
   input logic [DW-1:0] lv_level,
   input lregion_e      lv_region,
   input logic          rp_vld,
   input logic [DW-1:0] rp_val,
   input logic [CW-1:0] rp_cnt,
   input lregion_e      rp_region,
   input logic [DW-1:0] blank_lvl,
   input logic [DW-1:0] sync_lvl,
   input logic          out_valid
);

   // R8
   first_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rp_vld |=> (out_valid && !rp_vld));

   // R8
   second_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(rp_vld)) |=> out_valid);

   // R7
   ramp_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lv_vld && lv_region != rp_region) |=> (rp_vld && rp_cnt == CW'(1)));

   // R6
   ramp_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rp_vld && rp_cnt == CW'(RAMP_LEN)) |-> (rp_val == lv_level));

   // R6
   ramp_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rp_vld |-> (rp_cnt >= CW'(1) && rp_cnt <= CW'(RAMP_LEN)));

   // R3
   sync_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rp_vld && rp_cnt == CW'(RAMP_LEN) && lv_region == REG_SYNC) |-> (rp_val == sync_lvl));

   // R5
   blank_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rp_vld && rp_cnt == CW'(RAMP_LEN) && lv_region == REG_BLANK) |-> (rp_val == blank_lvl));

endmodule

bind luma_sync_inserter luma_sync_inserter_chk #(
   .DW(DW), .RAMP_LEN(RAMP_LEN), .CW(CW)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lv_vld   (lv_vld),
   .lv_level (lv_level),
   .lv_region(lv_region),
   .rp_vld   (rp_vld),
   .rp_val   (rp_val),
   .rp_cnt   (rp_cnt),
   .rp_region(rp_region),
   .blank_lvl(blank_lvl),
   .sync_lvl (sync_lvl),
   .out_valid(out_valid)
);

// File: tb/test_luma_sync_inserter.sv
module test_luma_sync_inserter;

   localparam int CLK_PERIOD = 10;
   localparam int DLY        = 6;

   typedef struct {
      int    l;
      bit    h;
      bit    v;
      bit    a;
      string tag;
   } pix_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pix_valid = 1'b0;
   logic [9:0] luma_in = '0;
   logic       hsync_in = 1'b0, vsync_in = 1'b0, active_in = 1'b0;
   logic [9:0] gain = 10'h200, black_lvl = 10'd240, blank_lvl = 10'd200, sync_lvl = 10'd16;
   logic       out_valid;
   logic [9:0] out_data;

   int n_cmp = 0, n_bad = 0, n_in = 0, n_out = 0;
   bit done = 0;

   pix_t  dq[$];
   int    exp_v[$];
   string exp_t[$];
   int    m_region = 0, m_cnt = 4, m_start = 0, m_last = 0;
   int    f0 = 0, f1 = 0, f2 = 0, f3 = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   luma_sync_inserter #(.DLY(DLY)) i_luma_sync_inserter (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .luma_in(luma_in),
      .hsync_in(hsync_in), .vsync_in(vsync_in), .active_in(active_in),
      .gain(gain), .black_lvl(black_lvl), .blank_lvl(blank_lvl), .sync_lvl(sync_lvl),
      .out_valid(out_valid), .out_data(out_data)
   );

   task automatic check(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int clip(int x);
      return (x < 0) ? 0 : ((x > 1023) ? 1023 : x);
   endfunction

   task automatic model_push(pix_t p);
      pix_t  q;
      int    sc, region, tgt, d, o, odd;
      bit    sat;
      string tag;
      dq.push_back(p);
      q   = dq.pop_front();
      sc  = (q.l * int'(gain)) / 512;
      sat = (sc > 1023);
      if (sat) sc = 1023;
      if (q.h || q.v) begin region = 2; tgt = int'(sync_lvl); tag = "R3"; end
      else if (q.a) begin region = 1; tgt = clip(int'(black_lvl) + sc); tag = sat ? "R2" : "R4"; end
      else begin region = 0; tgt = int'(blank_lvl); tag = "R5"; end
      if (q.tag == "R1") tag = "R1";
      if (region != m_region) begin
         tag = (m_cnt < 4) ? "R7" : "R6";
         m_cnt = 1; m_start = m_last; m_region = region;
      end else if (m_cnt < 4) begin
         m_cnt++; tag = "R6";
      end
      d = (tgt - m_start) * m_cnt;
      o = m_start + (d >>> 2);
      m_last = o;
      f3 = f2; f2 = f1; f1 = f0; f0 = o;
      exp_v.push_back(f2); exp_t.push_back(tag);
      odd = clip((9 * (f2 + f1) - f3 - f0 + 8) >>> 4);
      exp_v.push_back(odd); exp_t.push_back("R9");
   endtask

   task automatic push(int l, bit h, bit v, bit a, int gap);
      pix_t p;
      @(posedge clk); #1;
      luma_in = 10'(l); hsync_in = h; vsync_in = v; active_in = a; pix_valid = 1'b1;
      p.l = l; p.h = h; p.v = v; p.a = a; p.tag = "";
      model_push(p);
      n_in++;
      @(posedge clk); #1;
      pix_valid = 1'b0;
      repeat (gap) @(posedge clk);
   endtask

   task automatic run(int n, bit h, bit v, bit a);
      for (int i = 0; i < n; i++) push(int'($urandom_range(0, 1023)), h, v, a, 0);
   endtask

   task automatic drain();
      repeat (24) @(posedge clk);
      #1;
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         n_out++;
         if (exp_v.size() == 0) begin
            check("R8", int'(out_data), -1);
         end else begin
            check(exp_t.pop_front(), int'(out_data), exp_v.pop_front());
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      pix_t z;
      void'($urandom(32'd4242));
      z.l = 0; z.h = 0; z.v = 0; z.a = 0; z.tag = "R1";
      for (int i = 0; i < DLY; i++) dq.push_back(z);
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", int'(out_valid), 0);
      check("R10", int'(out_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", int'(out_valid), 0);
      check("R10", int'(out_data), 0);

      // R1, R5, R3, R6, R4: a directed line with unity gain
      run(10, 0, 0, 0);
      run(8, 1, 0, 0);
      run(6, 0, 0, 0);
      run(20, 0, 0, 1);
      run(6, 0, 0, 0);
      drain();

      // R2: saturation at full gain with bright luma
      gain = 10'h3FF; black_lvl = 10'd300;
      for (int i = 0; i < 10; i++) push(1023 - i, 0, 0, 1, 1);
      push(0, 0, 0, 1, 0);
      push(1, 0, 0, 1, 0);
      run(5, 0, 0, 0);
      drain();

      // R3: sync wins over active; vsync alone; R7 rapid toggles
      gain = 10'h180; black_lvl = 10'd60; blank_lvl = 10'd64; sync_lvl = 10'd0;
      run(5, 1, 1, 1);
      run(5, 0, 1, 0);
      for (int i = 0; i < 12; i++) push(1000, i[1], 0, !i[1], 0);
      push(900, 0, 0, 1, 0);
      push(900, 1, 0, 0, 0);
      push(900, 0, 0, 0, 0);
      run(6, 0, 0, 0);
      drain();

      // constrained random runs with random gaps and setting changes
      for (int g = 0; g < 6; g++) begin
         gain = 10'($urandom_range(0, 1023));
         black_lvl = 10'($urandom_range(0, 400));
         blank_lvl = 10'($urandom_range(0, 300));
         sync_lvl = 10'($urandom_range(0, 100));
         for (int r = 0; r < 20; r++) begin
            int  len  = int'($urandom_range(1, 9));
            int  mode = int'($urandom_range(0, 3));
            for (int k = 0; k < len; k++)
               push(int'($urandom_range(0, 1023)), mode == 1, mode == 2, mode != 0,
                    int'($urandom_range(0, 2)));
         end
         drain();
      end

      // R8: two outputs per pixel, nothing left over
      check("R8", n_out, 2 * n_in);
      check("R8", exp_v.size(), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule